// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a run of consecutive bytes out of a one-time-programmable fuse macro. Its input is a one-cycle start pulse, a start address, a byte count and a variant select. It then drives the macro's control word through an entry step, a per-byte address-and-strobe cycle, and an exit step. Every wait between steps has a fixed length in microseconds, counted in system clocks. After each strobe it takes the macro's data byte and writes it to a local buffer through a write-enable/address/data port. At the end it pulses `done` and reports how many bytes it read.

Two variants are supported. Variant A opens a session by first driving chip-select inactive. It then enables the macro with chip-select active, load and program-disable, and it closes the session by driving chip-select inactive again. Variant B enables the macro with load alone and closes the session by clearing load. The two variants put the address field at different bit positions of the control word, because the macros that each variant serves decode different positions. The boot-time use is a 32-byte read from address 0.

Top module: `fuse_rd_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `done` and `buf_we` are 0 and `fuse_ctrl` is all zeros.
- R2: A start with `byte_count` = 0 raises `done` in the cycle after it is accepted, reports `bytes_read` = 0 and leaves `fuse_ctrl` unchanged in every bit, whatever `mode` is.
- R3: With `mode` = 0 (variant A), the first busy cycle drives `fuse_ctrl` = 0x1, which is chip-select-inactive (bit 0) alone. The next 2·P cycles drive 0xC, which is load (bit 2) plus program-disable (bit 3) with chip-select active. P is clocks per microsecond.
- R4: With `mode` = 1 (variant B), the first busy cycle drives `fuse_ctrl` = 0x4 (load alone). Bit 0 and bit 3 stay 0 for the whole session.
- R5: For each byte the address field is 0 for one cycle and then holds the byte address for 2·P cycles. After that, strobe (bit 1) is high for exactly 2·P cycles and then low for 2·P cycles. The control word does not change while strobe is high, and strobe is only ever high with load set.
- R6: `fuse_dout` is sampled in the last strobe-high cycle. In the next cycle `buf_we` pulses for one cycle with `buf_addr` = byte index (counting from 0) and `buf_data` = the sampled byte.
- R7: Byte k is read from address (start_addr + k) mod 2^AW. The field sits at bits [SHIFT_A+AW-1:SHIFT_A] (default [17:8]) in variant A and at bits [SHIFT_B+AW-1:SHIFT_B] (default [29:20]) in variant B.
- R8: After the last byte's strobe-low wait comes a 2·P-cycle wait. Then variant A sets bit 0 and variant B clears bit 2, and `done` rises exactly P cycles later.
- R9: `busy` is high from the cycle after an accepted start through the cycle in which `done` is high. `done` is a one-cycle pulse, and at `done` `bytes_read` equals `byte_count`. A session with N bytes has (A:1, B:0) + 2P + N·(1+6P) + 3P busy cycles before `done`.
- R10: A start pulse that arrives while `busy` is high, including the `done` cycle, is ignored. The running session's addresses, data, count and length are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| mode | input | 1 | Variant select: 0 = A, 1 = B |
| start_addr | input | AW | First fuse byte address |
| byte_count | input | LEN_W | Number of bytes to read |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle completion pulse |
| bytes_read | output | LEN_W | Bytes captured in the current or last session |
| fuse_ctrl | output | CTRL_W | Control word to the fuse macro |
| fuse_dout | input | DW | Data byte from the fuse macro |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | LEN_W | Buffer write index |
| buf_data | output | DW | Buffer write data |

## Verification
The two functions that can land in the same cycle are completion and request acceptance: a new start pulse can arrive exactly in the cycle where `done` is high. The bench raises `start` with a new count in that very cycle. It judges the outcome by `busy` and `done` both being low one cycle later, which shows the request was dropped. A second stray start sent in the middle of a session, carrying a different address and count, has to leave every captured byte, the byte count and the session length exactly as predicted for the original request.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CS_OFF,
        S_OPEN,
        S_ACLR,
        S_ASET,
        S_STRB,
        S_SLOW,
        S_TAIL,
        S_CLOSE,
        S_DONE
    } seq_state_e;

    // Control word bit positions decoded by the macro.
    localparam int CSB_BIT   = 0;
    localparam int STRB_BIT  = 1;
    localparam int LOAD_BIT  = 2;
    localparam int PGENB_BIT = 3;

    typedef struct packed {
        logic csb;
        logic strobe;
        logic load;
        logic pgenb;
    } pin_set_t;

    localparam pin_set_t PINS_CS_OFF = '{csb: 1'b1, strobe: 1'b0, load: 1'b0, pgenb: 1'b0};
    localparam pin_set_t PINS_OPEN_A = '{csb: 1'b0, strobe: 1'b0, load: 1'b1, pgenb: 1'b1};
    localparam pin_set_t PINS_OPEN_B = '{csb: 1'b0, strobe: 1'b0, load: 1'b1, pgenb: 1'b0};

    // Successor of a timed state once its wait has expired.
    function automatic seq_state_e step(seq_state_e s, logic last_byte);
        seq_state_e r;
        case (s)
            S_CS_OFF: r = S_OPEN;
            S_OPEN:   r = S_ACLR;
            S_ACLR:   r = S_ASET;
            S_ASET:   r = S_STRB;
            S_STRB:   r = S_SLOW;
            S_SLOW:   r = last_byte ? S_TAIL : S_ACLR;
            S_TAIL:   r = S_CLOSE;
            S_CLOSE:  r = S_DONE;
            default:  r = S_IDLE;
        endcase
        return r;
    endfunction

    // Length of each state in microseconds; 0 means a single cycle.
    function automatic int unsigned state_us(seq_state_e s);
        int unsigned r;
        case (s)
            S_OPEN, S_ASET, S_STRB, S_SLOW, S_TAIL: r = 2;
            S_CLOSE:                                r = 1;
            default:                                r = 0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fuse_rd_timer.sv
module fuse_rd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fuse_rd_fsm.sv
module fuse_rd_fsm
    import fuse_rd_pkg::*;
#(
    parameter int CLKS_PER_US = 200,
    parameter int AW          = 10,
    parameter int LEN_W       = 6,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode,
    input  logic [AW-1:0]    start_addr,
    input  logic [LEN_W-1:0] byte_count,
    input  logic             expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output pin_set_t         pins,
    output logic [AW-1:0]    afield,
    output logic             mode_q,
    output logic             accept,
    output logic             sample,
    output logic [LEN_W-1:0] ptr,
    output logic             busy,
    output logic             done
);
    seq_state_e       state_q, nxt;
    pin_set_t         pins_q;
    logic [AW-1:0]    afield_q, addr_q;
    logic [LEN_W-1:0] left_q, ptr_q;
    logic             mode_r, go, mode_eff;

    always_comb begin
        nxt = state_q;
        go  = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (start) begin
                    go  = 1'b1;
                    nxt = (byte_count == '0) ? S_DONE : (mode ? S_OPEN : S_CS_OFF);
                end
            end
            S_DONE: nxt = S_IDLE;
            default: begin
                if (expired) begin
                    go  = 1'b1;
                    nxt = step(state_q, left_q == LEN_W'(1));
                end
            end
        endcase
    end

    always_comb begin
        int unsigned us;
        us = state_us(nxt);
        tmr_val = (us == 0) ? '0 : CNT_W'(us * CLKS_PER_US - 1);
    end

    assign tmr_load = go;
    assign mode_eff = (state_q == S_IDLE) ? mode : mode_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            pins_q   <= '0;
            afield_q <= '0;
            addr_q   <= '0;
            left_q   <= '0;
            ptr_q    <= '0;
            mode_r   <= 1'b0;
        end else begin
            if (go || state_q == S_DONE) state_q <= nxt;
            if (state_q == S_IDLE && start && byte_count != '0) begin
                mode_r <= mode;
                addr_q <= start_addr;
                left_q <= byte_count;
                ptr_q  <= '0;
            end
            if (go) begin
                case (nxt)
                    S_CS_OFF: begin
                        pins_q   <= PINS_CS_OFF;
                        afield_q <= '0;
                    end
                    S_OPEN: begin
                        pins_q   <= mode_eff ? PINS_OPEN_B : PINS_OPEN_A;
                        afield_q <= '0;
                    end
                    S_ACLR: begin
                        afield_q <= '0;
                        if (state_q == S_SLOW) begin
                            addr_q <= addr_q + 1'b1;
                            ptr_q  <= ptr_q + 1'b1;
                            left_q <= left_q - 1'b1;
                        end
                    end
                    S_ASET:  afield_q <= addr_q;
                    S_STRB:  pins_q.strobe <= 1'b1;
                    S_SLOW:  pins_q.strobe <= 1'b0;
                    S_CLOSE: begin
                        if (mode_r) pins_q.load <= 1'b0;
                        else        pins_q.csb  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pins   = pins_q;
    assign afield = afield_q;
    assign mode_q = mode_r;
    assign accept = (state_q == S_IDLE) && start;
    assign sample = (state_q == S_STRB) && expired;
    assign ptr    = ptr_q;
    assign busy   = (state_q != S_IDLE);
    assign done   = (state_q == S_DONE);
endmodule

// File: rtl/fuse_rd_word.sv
module fuse_rd_word
    import fuse_rd_pkg::*;
#(
    parameter int AW      = 10,
    parameter int CTRL_W  = 32,
    parameter int SHIFT_A = 8,
    parameter int SHIFT_B = 20
) (
    input  pin_set_t          pins,
    input  logic [AW-1:0]     afield,
    input  logic              mode_q,
    output logic [CTRL_W-1:0] word
);
    always_comb begin
        word            = '0;
        word[CSB_BIT]   = pins.csb;
        word[STRB_BIT]  = pins.strobe;
        word[LOAD_BIT]  = pins.load;
        word[PGENB_BIT] = pins.pgenb;
        if (mode_q) word[SHIFT_B +: AW] = afield;
        else        word[SHIFT_A +: AW] = afield;
    end
endmodule

// File: rtl/fuse_rd_capture.sv
module fuse_rd_capture #(
    parameter int LEN_W = 6,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample,
    input  logic [LEN_W-1:0] ptr,
    input  logic [DW-1:0]    din,
    output logic             we,
    output logic [LEN_W-1:0] waddr,
    output logic [DW-1:0]    wdata,
    output logic [LEN_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            we    <= 1'b0;
            waddr <= '0;
            wdata <= '0;
            count <= '0;
        end else begin
            we <= sample;
            if (sample) begin
                waddr <= ptr;
                wdata <= din;
            end
            if (clear)       count <= '0;
            else if (sample) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int CLKS_PER_US = 200,
    parameter int AW          = 10,
    parameter int LEN_W       = 6,
    parameter int DW          = 8,
    parameter int CTRL_W      = 32,
    parameter int SHIFT_A     = 8,
    parameter int SHIFT_B     = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [AW-1:0]     start_addr,
    input  logic [LEN_W-1:0]  byte_count,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  bytes_read,
    output logic [CTRL_W-1:0] fuse_ctrl,
    input  logic [DW-1:0]     fuse_dout,
    output logic              buf_we,
    output logic [LEN_W-1:0]  buf_addr,
    output logic [DW-1:0]     buf_data
);
    localparam int CNT_W = $clog2(2 * CLKS_PER_US);

    logic             tmr_load, expired, accept, sample, mode_q;
    logic [CNT_W-1:0] tmr_val;
    pin_set_t         pins;
    logic [AW-1:0]    afield;
    logic [LEN_W-1:0] ptr;

    fuse_rd_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(expired)
    );

    fuse_rd_fsm #(
        .CLKS_PER_US(CLKS_PER_US), .AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .start_addr(start_addr), .byte_count(byte_count), .expired(expired),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .pins(pins), .afield(afield),
        .mode_q(mode_q), .accept(accept), .sample(sample), .ptr(ptr),
        .busy(busy), .done(done)
    );

    fuse_rd_word #(
        .AW(AW), .CTRL_W(CTRL_W), .SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)
    ) u_word (
        .pins(pins), .afield(afield), .mode_q(mode_q), .word(fuse_ctrl)
    );

    fuse_rd_capture #(.LEN_W(LEN_W), .DW(DW)) u_cap (
        .clk(clk), .rst(rst), .clear(accept), .sample(sample), .ptr(ptr),
        .din(fuse_dout), .we(buf_we), .waddr(buf_addr), .wdata(buf_data),
        .count(bytes_read)
    );
endmodule

// File: rtl/fuse_rd_seq_chk.sv
module fuse_rd_seq_chk
    import fuse_rd_pkg::*;
#(
    parameter int CTRL_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              mode_q,
    input logic              buf_we,
    input logic [CTRL_W-1:0] fuse_ctrl
);
    // R5: control word frozen while strobe stays high
    a_r5_word_hold: assert property (@(posedge clk) disable iff (rst)
        (fuse_ctrl[STRB_BIT] && $past(fuse_ctrl[STRB_BIT])) |-> $stable(fuse_ctrl));

    // R5: strobe only with load set
    a_r5_strobe_loaded: assert property (@(posedge clk) disable iff (rst)
        fuse_ctrl[STRB_BIT] |-> fuse_ctrl[LOAD_BIT]);

    // R6: buffer write follows a strobe-high cycle
    a_r6_we_after_strobe: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> $past(fuse_ctrl[STRB_BIT]));

    // R4: variant B never touches chip-select or program-disable
    a_r4_varb_quiet: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_q) |-> (!fuse_ctrl[CSB_BIT] && !fuse_ctrl[PGENB_BIT]));

    // R9: done is a single-cycle pulse inside busy
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R9: busy holds until done
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(.CTRL_W(CTRL_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .mode_q(mode_q),
    .buf_we(buf_we), .fuse_ctrl(fuse_ctrl)
);

// File: tb/fuse_rd_seq_tb.sv
module fuse_rd_seq_tb;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [9:0]  addr_i = '0;
    logic [5:0]  cnt_i = '0;
    logic        busy, done, buf_we;
    logic [5:0]  bytes_read, buf_addr;
    logic [31:0] ctrl;
    logic [7:0]  dout, buf_data;
    logic        cur_mode = 1'b0;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fuse_rd_seq #(.CLKS_PER_US(P)) u_dut (
        .clk(clk), .rst(rst), .start(start_i), .mode(mode_i),
        .start_addr(addr_i), .byte_count(cnt_i), .busy(busy), .done(done),
        .bytes_read(bytes_read), .fuse_ctrl(ctrl), .fuse_dout(dout),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data)
    );

    function automatic logic [7:0] rom(logic [9:0] a);
        return (a[7:0] * 8'd29) + {a[9:8], 6'h2A};
    endfunction

    function automatic logic [9:0] field_of(logic [31:0] w, logic m);
        return m ? w[29:20] : w[17:8];
    endfunction

    // Fuse macro model: byte ROM, valid only while enabled and strobed.
    assign dout = (ctrl[1] && ctrl[2] && !(ctrl[0] && !cur_mode))
                  ? rom(field_of(ctrl, cur_mode)) : 8'h00;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Vector: [16] mode, [15:6] start address, [5:0] count
    localparam logic [16:0] VECS [0:5] = '{
        {1'b0, 10'd0,    6'd32},
        {1'b1, 10'd0,    6'd32},
        {1'b0, 10'd1021, 6'd6},
        {1'b1, 10'd1000, 6'd1},
        {1'b0, 10'd77,   6'd3},
        {1'b1, 10'd513,  6'd9}
    };

    task automatic run_session(input logic m, input logic [9:0] a,
                               input logic [5:0] n, input bit poke, input bit collide);
        int idx = 0, k = 0, run = 0, exit_idx = -1000, expl;
        bit bad_b = 0;
        logic [31:0] prev;
        cur_mode = m; mode_i = m; addr_i = a; cnt_i = n; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        prev = ctrl;
        chk(ctrl == (m ? 32'h4 : 32'h1), m ? "R4" : "R3", "entry word", ctrl, m ? 4 : 1);
        while (!done && idx < 5000) begin
            if (idx == 1 && !m) chk(ctrl == 32'hC, "R3", "open word", ctrl, 12);
            if (m && (ctrl[0] || ctrl[3])) bad_b = 1;
            if (ctrl[1] && !prev[1]) begin
                chk(field_of(ctrl, m) == 10'(a + k), "R7", "strobe address",
                    field_of(ctrl, m), 10'(a + k));
                run = 0;
            end
            if (ctrl[1]) run++;
            if (!ctrl[1] && prev[1]) chk(run == 2 * P, "R5", "strobe width", run, 2 * P);
            if (buf_we) begin
                chk(buf_addr == 6'(k), "R6", "write index", buf_addr, k);
                chk(buf_data == rom(10'(a + k)), "R6", "write data", buf_data, rom(10'(a + k)));
                k++;
            end
            if (!m && ctrl[0] && !prev[0]) exit_idx = idx;
            if (m && !ctrl[2] && prev[2]) exit_idx = idx;
            if (poke && idx == 40) begin
                start_i = 1'b1; addr_i = a + 10'd300; cnt_i = 6'd2; mode_i = ~m;
            end
            if (poke && idx == 41) begin
                start_i = 1'b0; addr_i = a; cnt_i = n; mode_i = m;
            end
            prev = ctrl;
            idx++;
            @(negedge clk);
        end
        expl = (m ? 0 : 1) + 2 * P + n * (1 + 6 * P) + 3 * P;
        chk(idx == expl, "R9", "busy length", idx, expl);
        chk(k == n, "R6", "write count", k, n);
        chk(bytes_read == n, "R9", "bytes_read", bytes_read, n);
        chk(idx - exit_idx == P, "R8", "exit to done", idx - exit_idx, P);
        chk(m ? !ctrl[2] : ctrl[0], "R8", "exit pin", ctrl, 0);
        if (m) chk(!bad_b, "R4", "cs/pgenb quiet", bad_b, 0);
        if (collide) begin
            start_i = 1'b1; cnt_i = 6'd5;
            @(negedge clk);
            start_i = 1'b0;
            chk(!busy && !done, "R10", "start in done cycle ignored", busy, 0);
        end else begin
            @(negedge clk);
            chk(!busy, "R9", "busy falls after done", busy, 0);
        end
        cnt_i = n; addr_i = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !buf_we && ctrl == 0, "R1", "reset state", ctrl, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !buf_we && ctrl == 0, "R1", "after reset", ctrl, 0);

        for (int i = 0; i < 6; i++) begin
            run_session(VECS[i][16], VECS[i][15:6], VECS[i][5:0], i == 2, i == 3);
            repeat (2) @(negedge clk);
        end

        // R2: zero-length request after a variant A session, opposite mode
        run_session(1'b0, 10'd500, 6'd2, 0, 0);
        w = ctrl;
        mode_i = 1'b1; cnt_i = 6'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done == 1'b1, "R2", "zero-length done", done, 1);
        chk(bytes_read == 0, "R2", "zero-length count", bytes_read, 0);
        chk(ctrl == w, "R2", "pins unchanged", ctrl, w);
        @(negedge clk);
        chk(!busy && ctrl == w, "R2", "idle, pins unchanged", ctrl, w);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule